// File: doc/BRIEF.md
# Bus Reply Packet Checker

This block is a synthesizable monitor for the reply side of a 64-bit packet bus. Before traffic flows, a test environment loads the replies it expects into an internal queue. Each queue entry holds a header word, four data words and four double-error marks. The monitor then watches the bus grant, a header strobe, the data bus and an error line, and checks each reply packet that appears against the oldest queued entry.

The bus grant is registered once before use, so that it lines up with the header and data cycles of the packet it covers. A packet starts on a cycle where the header strobe is high and the registered grant is high. On that cycle the oldest entry is popped and the bus word must equal its header. The monitor decodes the command field of the header to find the packet length and the check rule for each data cycle. Any mismatch or protocol fault sets a sticky error flag. A cause code records the first fault and holds it until reset.

The control has two states. `S_IDLE` waits for a header: *accept* moves to `S_DATA`, while *reject* (underflow or unknown command) stays in `S_IDLE`. `S_DATA` checks the data cycles: *step* stays in `S_DATA` while data cycles remain, *finish* returns to `S_IDLE` after the last data cycle, and *abort* returns to `S_IDLE` when the grant drops or a header strobe arrives inside a packet.

Top module: `reply_pkt_checker`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), `queue_empty` is 1, `err_flag` is 0 and `err_cause` is 0. Reset clears the queue, the packet state, the registered grant and the latched cause.
- R2: The grant is registered for one cycle. A header is accepted only if `bus_grant` was high in the cycle before the header strobe. A header strobe without that earlier grant is ignored: nothing is popped and no error is raised.
- R3: On an accepted header, the oldest queue entry is popped. If `bus_data` differs from the entry's header word, the cause is 1.
- R4: The command is header bits [63:59]. The reply commands are 0x01 read-block, 0x03 write-block, 0x05 flush-block, 0x07 write-shared, 0x09 conditional-write-shared, 0x0B broadcast-IO-write, 0x0D demap, 0x0F IO-write and 0x11 IO-read. Read-block and conditional-write-shared packets last 5 cycles. All other packets last 2 cycles. A header in the cycle right after a packet ends starts a new packet without error.
- R5: A header strobe during a data cycle of a packet gives cause 2, and the packet is abandoned.
- R6: A low registered grant during a data cycle of a packet gives cause 3, and the packet is abandoned.
- R7: On a read-block data cycle whose word is marked double-error, `bus_err` must be 1 (cause 5 if it is not) and the data is not compared. On an unmarked word, the data must match the expected word at that index (cause 4).
- R8: On data cycles of the other 2-cycle replies, a high `bus_err` gives cause 6. Otherwise, the data must match expected word 0 (cause 4).
- R9: On conditional-write-shared replies, `bus_err` must be 0 (cause 6) and every one of the four data cycles is compared against expected word 0 (cause 4).
- R10: An accepted header whose command is not one of the nine replies gives cause 7, and no data cycles follow.
- R11: A header strobe with a high registered grant while the queue is empty gives cause 8.
- R12: The queue holds `DEPTH` entries (8 by default). A push into a full queue is refused, the stored entries are unchanged, and the cause is 9.
- R13: `err_flag` is 1 exactly when `err_cause` is non-zero. The first cause holds until reset, even when later faults occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| exp_push | input | 1 | Load one expected reply into the queue |
| exp_header | input | 64 | Expected header word |
| exp_data | input | 256 | Expected data words, word i at bits [64i+63:64i] |
| exp_dbl_err | input | 4 | Double-error mark per data word, bit i for word i |
| bus_grant | input | 1 | Data bus grant, registered once before use |
| bus_hdr | input | 1 | Header-cycle strobe |
| bus_data | input | 64 | Bus data word |
| bus_err | input | 1 | Bus error line |
| err_flag | output | 1 | Sticky error flag |
| err_cause | output | 4 | First error cause code, 0 when none |
| queue_empty | output | 1 | Expected-reply queue holds no entry |

## Verification
The monitor evaluates the bus inputs of a cycle at the clock edge that ends that cycle. A cause therefore appears on `err_cause` right after that edge, and a pop shows on `queue_empty` right after the edge of the header cycle. A refused push shows its cause right after the edge where it was presented. Because the grant passes through one register, the bench raises `bus_grant` one cycle before each header. The bench drives inputs on the falling edge and samples the outputs 1 ns after the following rising edge, so each check reads the result of exactly the cycle it just drove.

// File: rtl/rpc_pkg.sv
package rpc_pkg;

    localparam int CMD_W = 5;

    localparam logic [CMD_W-1:0] CMD_RD_BLK  = 5'h01;
    localparam logic [CMD_W-1:0] CMD_WR_BLK  = 5'h03;
    localparam logic [CMD_W-1:0] CMD_FL_BLK  = 5'h05;
    localparam logic [CMD_W-1:0] CMD_WR_SHR  = 5'h07;
    localparam logic [CMD_W-1:0] CMD_CW_SHR  = 5'h09;
    localparam logic [CMD_W-1:0] CMD_BIO_WR  = 5'h0B;
    localparam logic [CMD_W-1:0] CMD_DEMAP   = 5'h0D;
    localparam logic [CMD_W-1:0] CMD_IO_WR   = 5'h0F;
    localparam logic [CMD_W-1:0] CMD_IO_RD   = 5'h11;

    typedef enum logic [1:0] {
        KIND_RD_BLK,
        KIND_CW_SHR,
        KIND_PLAIN,
        KIND_BAD
    } kind_e;

    typedef enum logic [3:0] {
        CAUSE_NONE      = 4'd0,
        CAUSE_HDR_BAD   = 4'd1,
        CAUSE_HDR_IN    = 4'd2,
        CAUSE_GRANT     = 4'd3,
        CAUSE_DATA      = 4'd4,
        CAUSE_ERR_MISS  = 4'd5,
        CAUSE_ERR_EXTRA = 4'd6,
        CAUSE_CMD_BAD   = 4'd7,
        CAUSE_UNDERFLOW = 4'd8,
        CAUSE_OVERFLOW  = 4'd9
    } cause_e;

    typedef enum logic {
        S_IDLE,
        S_DATA
    } state_e;

endpackage

// File: rtl/rpc_queue.sv
module rpc_queue #(
    parameter int WIDTH = 324,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             overflow
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             full, do_push, do_pop;

    assign full     = (count == FULL_CNT);
    assign empty    = (count == '0);
    assign do_push  = push && !full;
    assign do_pop   = pop && !empty;
    assign overflow = push && full;
    assign dout     = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    // R11: the checker never pops an empty queue
    assert_pop_not_empty_R11: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

    // R12: a refused push leaves the fill level unchanged
    assert_full_push_refused_R12: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (count == FULL_CNT));

endmodule

// File: rtl/rpc_cmd_decode.sv
module rpc_cmd_decode
    import rpc_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int CNT_W  = 3
) (
    input  logic [DATA_W-1:0] header,
    output kind_e             kind,
    output logic [CNT_W-1:0]  data_cycles
);
    localparam int CMD_LSB = DATA_W - CMD_W;

    logic [CMD_W-1:0] cmd;
    assign cmd = header[DATA_W-1:CMD_LSB];

    always_comb begin
        unique case (cmd)
            CMD_RD_BLK: kind = KIND_RD_BLK;
            CMD_CW_SHR: kind = KIND_CW_SHR;
            CMD_WR_BLK, CMD_FL_BLK, CMD_WR_SHR, CMD_BIO_WR,
            CMD_DEMAP, CMD_IO_WR, CMD_IO_RD: kind = KIND_PLAIN;
            default:    kind = KIND_BAD;
        endcase
    end

    always_comb begin
        unique case (kind)
            KIND_RD_BLK, KIND_CW_SHR: data_cycles = CNT_W'(4);
            KIND_PLAIN:               data_cycles = CNT_W'(1);
            default:                  data_cycles = '0;
        endcase
    end

endmodule

// File: rtl/reply_pkt_checker.sv
module reply_pkt_checker
    import rpc_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int WORDS  = 4,
    parameter int DEPTH  = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    exp_push,
    input  logic [DATA_W-1:0]       exp_header,
    input  logic [WORDS*DATA_W-1:0] exp_data,
    input  logic [WORDS-1:0]        exp_dbl_err,
    input  logic                    bus_grant,
    input  logic                    bus_hdr,
    input  logic [DATA_W-1:0]       bus_data,
    input  logic                    bus_err,
    output logic                    err_flag,
    output logic [3:0]              err_cause,
    output logic                    queue_empty
);
    localparam int ENTRY_W = DATA_W * (WORDS + 1) + WORDS;
    localparam int IDX_W   = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam int CNT_W   = $clog2(WORDS + 1);

    // queue entry layout: {dbl marks, data words, header}
    logic [ENTRY_W-1:0]      q_din, q_dout;
    logic                    q_pop, q_empty, q_ovf;
    logic [DATA_W-1:0]       head_hdr;
    logic [WORDS*DATA_W-1:0] head_data;
    logic [WORDS-1:0]        head_dbl;

    assign q_din     = {exp_dbl_err, exp_data, exp_header};
    assign head_hdr  = q_dout[DATA_W-1:0];
    assign head_data = q_dout[DATA_W +: WORDS*DATA_W];
    assign head_dbl  = q_dout[ENTRY_W-1 -: WORDS];

    rpc_queue #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) u_queue (
        .clk      (clk),
        .rst      (rst),
        .push     (exp_push),
        .din      (q_din),
        .pop      (q_pop),
        .dout     (q_dout),
        .empty    (q_empty),
        .overflow (q_ovf)
    );

    kind_e            bus_kind;
    logic [CNT_W-1:0] bus_cycles;

    rpc_cmd_decode #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_decode (
        .header      (bus_data),
        .kind        (bus_kind),
        .data_cycles (bus_cycles)
    );

    state_e                  state, state_nx;
    logic                    grant_d;
    kind_e                   cur_kind;
    logic [WORDS*DATA_W-1:0] cur_data;
    logic [WORDS-1:0]        cur_dbl;
    logic [CNT_W-1:0]        remain;
    logic [IDX_W-1:0]        idx;
    cause_e                  cause_q, pkt_cause, new_cause;
    logic                    accept;
    logic [IDX_W-1:0]        sel_idx;
    logic [DATA_W-1:0]       exp_word;

    assign sel_idx  = (cur_kind == KIND_CW_SHR) ? '0 : idx;
    assign exp_word = cur_data[sel_idx*DATA_W +: DATA_W];

    // next state, pop and packet fault cause
    always_comb begin
        state_nx  = state;
        pkt_cause = CAUSE_NONE;
        q_pop     = 1'b0;
        accept    = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (bus_hdr && grant_d) begin
                    if (q_empty) begin
                        pkt_cause = CAUSE_UNDERFLOW;          // reject
                    end else begin
                        q_pop = 1'b1;
                        if (bus_data != head_hdr)       pkt_cause = CAUSE_HDR_BAD;
                        else if (bus_kind == KIND_BAD)  pkt_cause = CAUSE_CMD_BAD;
                        if (bus_kind != KIND_BAD) begin
                            accept   = 1'b1;                  // accept
                            state_nx = S_DATA;
                        end
                    end
                end
            end
            S_DATA: begin
                if (!grant_d) begin
                    pkt_cause = CAUSE_GRANT;                  // abort
                    state_nx  = S_IDLE;
                end else if (bus_hdr) begin
                    pkt_cause = CAUSE_HDR_IN;                 // abort
                    state_nx  = S_IDLE;
                end else begin
                    if (cur_kind == KIND_RD_BLK) begin
                        if (cur_dbl[idx]) begin
                            if (!bus_err) pkt_cause = CAUSE_ERR_MISS;
                        end else if (bus_data != exp_word) begin
                            pkt_cause = CAUSE_DATA;
                        end
                    end else if (bus_err) begin
                        pkt_cause = CAUSE_ERR_EXTRA;
                    end else if (bus_data != exp_word) begin
                        pkt_cause = CAUSE_DATA;
                    end
                    if (remain == CNT_W'(1)) state_nx = S_IDLE; // finish, else step
                end
            end
            default: state_nx = S_IDLE;
        endcase
    end

    assign new_cause = (pkt_cause != CAUSE_NONE) ? pkt_cause :
                       (q_ovf ? CAUSE_OVERFLOW : CAUSE_NONE);

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= S_IDLE;
        else     state <= state_nx;
    end

    // packet context, retimed grant and latched cause
    always_ff @(posedge clk) begin
        if (rst) begin
            grant_d  <= 1'b0;
            cur_kind <= KIND_PLAIN;
            cur_data <= '0;
            cur_dbl  <= '0;
            remain   <= '0;
            idx      <= '0;
            cause_q  <= CAUSE_NONE;
        end else begin
            grant_d <= bus_grant;
            if (accept) begin
                cur_kind <= bus_kind;
                cur_data <= head_data;
                cur_dbl  <= head_dbl;
                remain   <= bus_cycles;
                idx      <= '0;
            end else if (state == S_DATA) begin
                remain <= (state_nx == S_IDLE) ? '0 : remain - 1'b1;
                idx    <= idx + 1'b1;
            end
            if (cause_q == CAUSE_NONE) cause_q <= new_cause;
        end
    end

    assign err_cause   = cause_q;
    assign err_flag    = (cause_q != CAUSE_NONE);
    assign queue_empty = q_empty;

    // R13: the first cause is held until reset
    assert_sticky_cause_R13: assert property (@(posedge clk) disable iff (rst)
        (err_cause != 4'd0) |=> $stable(err_cause) && err_flag);

    // R4: a packet in its data phase always has data cycles left
    assert_remain_live_R4: assert property (@(posedge clk) disable iff (rst)
        (state == S_DATA) |-> (remain != '0));

    // R6: a lost grant ends the packet
    assert_grant_abort_R6: assert property (@(posedge clk) disable iff (rst)
        (state == S_DATA && !grant_d) |=> (state == S_IDLE));

    // R5: a header inside a packet never starts a new one
    assert_no_nested_hdr_R5: assert property (@(posedge clk) disable iff (rst)
        (state == S_DATA) |-> !q_pop);

endmodule

// File: tb/reply_pkt_checker_tb.sv
`timescale 1ns/1ps
module reply_pkt_checker_tb;

    logic         clk = 1'b0;
    logic         rst;
    logic         exp_push;
    logic [63:0]  exp_header;
    logic [255:0] exp_data;
    logic [3:0]   exp_dbl_err;
    logic         bus_grant, bus_hdr, bus_err;
    logic [63:0]  bus_data;
    logic         err_flag, queue_empty;
    logic [3:0]   err_cause;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    reply_pkt_checker u_dut (
        .clk(clk), .rst(rst), .exp_push(exp_push), .exp_header(exp_header),
        .exp_data(exp_data), .exp_dbl_err(exp_dbl_err), .bus_grant(bus_grant),
        .bus_hdr(bus_hdr), .bus_data(bus_data), .bus_err(bus_err),
        .err_flag(err_flag), .err_cause(err_cause), .queue_empty(queue_empty)
    );

    localparam logic [4:0] VALID_CMDS [9] = '{5'h01, 5'h03, 5'h05, 5'h07, 5'h09,
                                              5'h0B, 5'h0D, 5'h0F, 5'h11};

    function automatic int data_len(input logic [4:0] cmd);
        return (cmd == 5'h01 || cmd == 5'h09) ? 4 : 1;
    endfunction

    function automatic logic [63:0] mk_hdr(input logic [4:0] cmd, input logic [58:0] low);
        return {cmd, low};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic g, input logic h, input logic [63:0] d, input logic e);
        @(negedge clk);
        exp_push = 1'b0; bus_grant = g; bus_hdr = h; bus_data = d; bus_err = e;
        @(posedge clk); #1;
    endtask

    task automatic push(input logic [63:0] h, input logic [255:0] d, input logic [3:0] dbl);
        @(negedge clk);
        exp_push = 1'b1; exp_header = h; exp_data = d; exp_dbl_err = dbl;
        bus_grant = 1'b0; bus_hdr = 1'b0; bus_err = 1'b0;
        @(posedge clk); #1;
        @(negedge clk);
        exp_push = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; exp_push = 1'b0; bus_grant = 1'b0; bus_hdr = 1'b0;
        bus_data = '0; bus_err = 1'b0; exp_header = '0; exp_data = '0; exp_dbl_err = '0;
        @(posedge clk); #1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    // send a correct packet; grant must already be registered high
    task automatic send_ok(input logic [63:0] h, input logic [255:0] d, input logic [3:0] dbl);
        int n;
        n = data_len(h[63:59]);
        drive(1'b1, 1'b1, h, 1'b0);
        for (int i = 0; i < n; i++) begin
            logic [63:0] w;
            logic        e;
            w = (h[63:59] == 5'h09) ? d[63:0] : d[i*64 +: 64];
            e = (h[63:59] == 5'h01) && dbl[i];
            drive(1'b1, 1'b0, e ? ~w : w, e);
        end
    endtask

    logic [255:0] dd;

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1;
        do_reset();

        // R1 reset state
        check("R1 queue_empty", queue_empty, 1);
        check("R1 err_flag", err_flag, 0);
        check("R1 err_cause", err_cause, 0);

        // R2 grant retimed: header with same-cycle grant is ignored
        dd = {4{64'h1111_2222_3333_4444}};
        push(mk_hdr(5'h03, 59'h15), dd, 4'h0);
        drive(1'b1, 1'b1, mk_hdr(5'h03, 59'h15), 1'b0);
        check("R2 ignored no pop", queue_empty, 0);
        check("R2 ignored no error", err_cause, 0);
        drive(1'b1, 1'b1, mk_hdr(5'h03, 59'h15), 1'b0);
        check("R2 accepted pop", queue_empty, 1);
        drive(1'b1, 1'b0, dd[63:0], 1'b0);
        check("R2 packet clean", err_cause, 0);

        // R3 header mismatch
        do_reset();
        push(mk_hdr(5'h03, 59'h1), dd, 4'h0);
        drive(1'b1, 1'b0, '0, 1'b0);
        drive(1'b1, 1'b1, mk_hdr(5'h03, 59'h2), 1'b0);
        check("R3 header mismatch", err_cause, 1);
        check("R3 pop on header", queue_empty, 1);
        check("R13 flag follows cause", err_flag, 1);

        // R13 first cause sticks through a later grant loss
        drive(1'b0, 1'b0, '0, 1'b0);
        drive(1'b0, 1'b0, '0, 1'b0);
        check("R13 first cause held", err_cause, 1);

        // R4 back-to-back: read-block (5 cycles) then 2-cycle reply
        do_reset();
        for (int i = 0; i < 4; i++) dd[i*64 +: 64] = 64'hA000 + 64'(i);
        push(mk_hdr(5'h01, 59'h7), dd, 4'h0);
        push(mk_hdr(5'h0F, 59'h8), dd, 4'h0);
        push(mk_hdr(5'h11, 59'h9), dd, 4'h0);
        drive(1'b1, 1'b0, '0, 1'b0);
        send_ok(mk_hdr(5'h01, 59'h7), dd, 4'h0);
        send_ok(mk_hdr(5'h0F, 59'h8), dd, 4'h0);
        send_ok(mk_hdr(5'h11, 59'h9), dd, 4'h0);
        check("R4 back-to-back lengths", err_cause, 0);
        check("R4 all popped", queue_empty, 1);

        // R5 header inside a read-block packet
        do_reset();
        push(mk_hdr(5'h01, 59'h3), dd, 4'h0);
        drive(1'b1, 1'b0, '0, 1'b0);
        drive(1'b1, 1'b1, mk_hdr(5'h01, 59'h3), 1'b0);
        drive(1'b1, 1'b0, dd[63:0], 1'b0);
        drive(1'b1, 1'b0, dd[127:64], 1'b0);
        check("R5 no error before", err_cause, 0);
        drive(1'b1, 1'b1, mk_hdr(5'h01, 59'h3), 1'b0);
        check("R5 header in packet", err_cause, 2);

        // R6 grant lost mid packet
        do_reset();
        push(mk_hdr(5'h09, 59'h3), dd, 4'h0);
        drive(1'b1, 1'b0, '0, 1'b0);
        drive(1'b0, 1'b1, mk_hdr(5'h09, 59'h3), 1'b0);
        drive(1'b0, 1'b0, dd[63:0], 1'b0);
        check("R6 grant lost", err_cause, 3);

        // R7 double-error word: error line high, data ignored
        do_reset();
        push(mk_hdr(5'h01, 59'h4), dd, 4'b0010);
        drive(1'b1, 1'b0, '0, 1'b0);
        drive(1'b1, 1'b1, mk_hdr(5'h01, 59'h4), 1'b0);
        drive(1'b1, 1'b0, dd[63:0], 1'b0);
        drive(1'b1, 1'b0, 64'hDEAD, 1'b1);
        drive(1'b1, 1'b0, dd[191:128], 1'b0);
        drive(1'b1, 1'b0, dd[255:192], 1'b0);
        check("R7 marked word accepted", err_cause, 0);
        // R7 marked word without error line
        do_reset();
        push(mk_hdr(5'h01, 59'h4), dd, 4'b0001);
        drive(1'b1, 1'b0, '0, 1'b0);
        drive(1'b1, 1'b1, mk_hdr(5'h01, 59'h4), 1'b0);
        drive(1'b1, 1'b0, dd[63:0], 1'b0);
        check("R7 error line missing", err_cause, 5);
        // R7 unmarked word with wrong index data
        do_reset();
        push(mk_hdr(5'h01, 59'h4), dd, 4'b0000);
        drive(1'b1, 1'b0, '0, 1'b0);
        drive(1'b1, 1'b1, mk_hdr(5'h01, 59'h4), 1'b0);
        drive(1'b1, 1'b0, dd[63:0], 1'b0);
        drive(1'b1, 1'b0, dd[63:0], 1'b0);
        check("R7 data mismatch", err_cause, 4);

        // R8 error line on plain reply
        do_reset();
        push(mk_hdr(5'h05, 59'h4), dd, 4'h0);
        drive(1'b1, 1'b0, '0, 1'b0);
        drive(1'b1, 1'b1, mk_hdr(5'h05, 59'h4), 1'b0);
        drive(1'b1, 1'b0, dd[63:0], 1'b1);
        check("R8 error line high", err_cause, 6);
        do_reset();
        push(mk_hdr(5'h0D, 59'h4), dd, 4'h0);
        drive(1'b1, 1'b0, '0, 1'b0);
        drive(1'b1, 1'b1, mk_hdr(5'h0D, 59'h4), 1'b0);
        drive(1'b1, 1'b0, dd[127:64], 1'b0);
        check("R8 data mismatch", err_cause, 4);

        // R9 conditional-write-shared compares word 0 each cycle
        do_reset();
        push(mk_hdr(5'h09, 59'h6), dd, 4'h0);
        drive(1'b1, 1'b0, '0, 1'b0);
        send_ok(mk_hdr(5'h09, 59'h6), dd, 4'h0);
        check("R9 word0 repeated", err_cause, 0);
        do_reset();
        push(mk_hdr(5'h09, 59'h6), dd, 4'h0);
        drive(1'b1, 1'b0, '0, 1'b0);
        drive(1'b1, 1'b1, mk_hdr(5'h09, 59'h6), 1'b0);
        drive(1'b1, 1'b0, dd[63:0], 1'b0);
        drive(1'b1, 1'b0, dd[127:64], 1'b0);
        check("R9 indexed word rejected", err_cause, 4);

        // R10 unknown command
        do_reset();
        push(mk_hdr(5'h02, 59'h6), dd, 4'h0);
        drive(1'b1, 1'b0, '0, 1'b0);
        drive(1'b1, 1'b1, mk_hdr(5'h02, 59'h6), 1'b0);
        check("R10 unknown command", err_cause, 7);

        // R11 underflow
        do_reset();
        drive(1'b1, 1'b0, '0, 1'b0);
        drive(1'b1, 1'b1, mk_hdr(5'h03, 59'h0), 1'b0);
        check("R11 underflow", err_cause, 8);

        // R12 overflow: ninth push refused, eight entries kept
        do_reset();
        for (int i = 0; i < 8; i++) push(mk_hdr(5'h07, 59'(i)), dd, 4'h0);
        check("R12 full no error", err_cause, 0);
        push(mk_hdr(5'h07, 59'h99), dd, 4'h0);
        check("R12 overflow", err_cause, 9);
        drive(1'b1, 1'b0, '0, 1'b0);
        for (int i = 0; i < 7; i++) send_ok(mk_hdr(5'h07, 59'(i)), dd, 4'h0);
        check("R12 one left", queue_empty, 0);
        send_ok(mk_hdr(5'h07, 59'd7), dd, 4'h0);
        check("R12 eight kept", queue_empty, 1);
        check("R13 overflow cause held", err_cause, 9);

        // random rounds covering R4 R7 R8 R9
        for (int r = 0; r < 12; r++) begin
            logic [63:0]  hs [4];
            logic [255:0] ds [4];
            logic [3:0]   bs [4];
            int n;
            do_reset();
            n = 1 + int'($urandom_range(3));
            for (int k = 0; k < n; k++) begin
                hs[k] = mk_hdr(VALID_CMDS[$urandom_range(8)], {27'($urandom), 32'($urandom)});
                for (int w = 0; w < 4; w++) ds[k][w*64 +: 64] = {32'($urandom), 32'($urandom)};
                bs[k] = 4'($urandom);
                push(hs[k], ds[k], bs[k]);
            end
            drive(1'b1, 1'b0, '0, 1'b0);
            for (int k = 0; k < n; k++) send_ok(hs[k], ds[k], bs[k]);
            check("R4 random stream clean", err_cause, 0);
            check("R4 random stream drained", queue_empty, 1);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule